// File: doc/BRIEF.md
# Asynchronous Serial Port with Parity and Receiver Wakeup

This block is a full-duplex asynchronous serial transmitter and receiver for a system bus. A programmable integer divider makes an oversampling tick, and each serial bit lasts sixteen ticks. Frames carry eight or nine data bits, least significant bit first. An optional parity bit, even or odd, follows the data, and one stop bit ends the frame. Software talks to the block through four word-wide registers: data, control, status and divider. Interrupt requests come out on three lines (transmit, receive, error). The transmit-ready and receive-ready conditions can also be steered to two DMA request lines.

The receiver majority-votes three mid-bit samples and reports noise, framing, parity and overrun faults. It can be placed in standby, where it drops incoming characters until a wakeup event occurs. The wakeup event is either a full character time of idle line or a character whose top data bit is set. Idle detection has two counting methods. A loop setting routes the transmitter output straight into the receiver, so the block can test itself with the receive pin cut off.

Register map (2-bit address): 0 = data (write: transmit character, read: received character, bits 8:0), 1 = control, 2 = status, 3 = divider. Control bits: 0 transmit enable, 1 receive enable, 2 nine-bit frames, 3 parity enable, 4 odd parity, 5 idle counting after stop bit, 6 address-mark wakeup, 7 standby, 8 loop, 9 transmit interrupt enable, 10 receive interrupt enable, 11 error interrupt enable, 12 transmit DMA select, 13 receive DMA select. Status bits: 0 transmit holding empty, 1 transmit complete, 2 receive full, 3 idle, 4 overrun, 5 noise, 6 framing error, 7 parity error.

Top module: `serial_port`

## Requirements
- R1: After reset, status reads 0x0001, the divider reads 0, txd is 1 and all interrupt and DMA request outputs are 0.
- R2: A frame is a 0 start bit, then 8 data bits (9 when control bit 2 is set) LSB first, then the parity bit when enabled, then a 1 stop bit. Each bit lasts 16 ticks, and one tick lasts D clocks for divider value D (0 counts as 1). A character sent in loop mode is received unchanged.
- R3: The parity bit makes the count of ones over data and parity even (control bit 4 = 0) or odd (bit 4 = 1). A received parity mismatch sets status bit 7.
- R4: Each received bit is the majority of oversampling samples 7, 8 and 9. If any bit of a frame has disagreeing samples, status bit 5 is set and the data is still the voted value.
- R5: A stop bit that votes 0 sets status bit 6, and the character is still stored.
- R6: A character that completes while status bit 2 is set sets status bit 4 and is discarded. The buffer keeps the earlier character.
- R7: Status bit 3 is set after a character time (16 times the frame bit count, in ticks) of continuous 1s. With control bit 5 = 0 the count runs from the start bit onward. With bit 5 = 1 it starts only once the stop bit has been received.
- R8: With control bit 7 (standby) and bit 6 set, characters whose top data bit is 0 are discarded. One with the top bit 1 clears bit 7 and is received.
- R9: With control bit 7 set and bit 6 clear, characters are discarded until an idle event (R7) after the last character, which clears bit 7.
- R10: With control bit 8 set, the receiver takes the transmitter output and ignores the rxd pin.
- R11: Status bit 0 is 1 while the transmit holding register is empty. Status bit 1 is set when the shifter finishes with nothing left to send, and is cleared by a data write.
- R12: irq_tx = bit 9 and (holding empty without bit 12, or transmit complete). irq_rx = bit 10 and (receive full without bit 13, or idle). irq_err = bit 11 and any of status bits 4 to 7. dma_tx_req = bits 12 and 0 and holding empty. dma_rx_req = bit 13 and receive full.
- R13: Reading the data register clears status bit 2. Writing 1 to status bits 1, 3, 4, 5, 6 or 7 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Receive error interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The round trip is swept over every 8-bit value with even parity and over a spread of 9-bit values with odd parity, in loop mode with the rxd pin held low. A wrong bit order, wrong parity sense, wrong frame length or a leak from the pin each corrupts some of these values. Hand-built frames on the pin carry a flipped parity bit, a zero stop bit and a one-tick glitch inside the voting window, and each isolates a single error flag. A frame ending in a run of ones separates the two idle counting methods by when the idle flag appears. Standby is tried with a low and a high top bit under address wakeup, and with a quiet gap under idle wakeup.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_BAUD = 2'd3;

  localparam int CTRL_W   = 14;
  localparam int C_TXEN   = 0;
  localparam int C_RXEN   = 1;
  localparam int C_NINE   = 2;
  localparam int C_PAREN  = 3;
  localparam int C_PODD   = 4;
  localparam int C_ISTOP  = 5;
  localparam int C_WADDR  = 6;
  localparam int C_SBY    = 7;
  localparam int C_LOOP   = 8;
  localparam int C_TXIE   = 9;
  localparam int C_RXIE   = 10;
  localparam int C_ERIE   = 11;
  localparam int C_TXDMA  = 12;
  localparam int C_RXDMA  = 13;

  localparam int MAXF = 12;
  localparam logic [7:0] W1C_MASK = 8'hFA;

  typedef enum logic {RX_IDLE, RX_RUN} rx_state_t;
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (({1'b0, cnt} + 1'b1) >= {1'b0, div}) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       load,
  input  logic [8:0] ld_data,
  input  logic       clr_done,
  output logic       txd,
  output logic       empty,
  output logic       done
);
  import sp_pkg::*;
  localparam int CW = $clog2(OVS);

  logic [8:0]      hold_data;
  logic            hold_full;
  logic            busy;
  logic [MAXF-1:0] shreg;
  logic [MAXF-1:0] fr;
  logic [3:0]      left;
  logic [3:0]      nbits;
  logic [CW-1:0]   cnt;
  logic            par;

  always_comb begin
    par   = (^(hold_data & (nine ? 9'h1FF : 9'h0FF))) ^ par_odd;
    nbits = 4'd10 + {3'd0, nine} + {3'd0, par_en};
    fr    = '1;
    fr[0] = 1'b0;
    fr[8:1] = hold_data[7:0];
    if (nine) begin
      fr[9] = hold_data[8];
      if (par_en) fr[10] = par;
    end else if (par_en) begin
      fr[9] = par;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      shreg     <= '1;
      left      <= '0;
      cnt       <= '0;
      txd       <= 1'b1;
      done      <= 1'b0;
    end else begin
      if (!busy && hold_full) begin
        shreg     <= fr;
        busy      <= 1'b1;
        cnt       <= '0;
        left      <= nbits;
        hold_full <= 1'b0;
        txd       <= 1'b0;
      end else if (busy && tick) begin
        if (cnt == CW'(OVS - 1)) begin
          cnt   <= '0;
          left  <= left - 1'b1;
          shreg <= {1'b1, shreg[MAXF-1:1]};
          if (left == 4'd1) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            if (!hold_full && !load) done <= 1'b1;
          end else begin
            txd <= shreg[1];
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (clr_done) done <= 1'b0;
      if (load) begin
        hold_data <= ld_data;
        hold_full <= 1'b1;
        done      <= 1'b0;
      end
    end
  end

  assign empty = !hold_full;

  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd) else $error("txd low while shifter idle"); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("complete while shifting"); // R11
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxin,
  input  logic       en,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       idle_mode,
  output logic       done,
  output logic [8:0] dout,
  output logic       noise,
  output logic       ferr,
  output logic       perr,
  output logic       idle_hit
);
  import sp_pkg::*;
  localparam int CW = $clog2(OVS);
  localparam int V0 = OVS / 2 - 1;
  localparam int IW = $clog2(MAXF * OVS + 1) + 1;

  rx_state_t       state;
  logic [CW-1:0]   cnt;
  logic [3:0]      bitidx;
  logic [2:0]      votes;
  logic [MAXF-1:0] sh;
  logic [MAXF-1:0] cur;
  logic            noisy;
  logic            maj, dis, last;
  logic [3:0]      nbits;
  logic [IW-1:0]   icnt;
  logic [IW-1:0]   char_ticks;
  logic            armed;
  logic            line_ok;
  logic [8:0]      rdat;
  logic            pbit, pexp;

  always_comb begin
    maj   = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
    dis   = !((votes == 3'b000) || (votes == 3'b111));
    nbits = 4'd10 + {3'd0, nine} + {3'd0, par_en};
    last  = (bitidx == nbits - 4'd1);
    cur   = sh;
    cur[bitidx] = maj;
    rdat  = nine ? cur[9:1] : {1'b0, cur[8:1]};
    pbit  = nine ? cur[10] : cur[9];
    pexp  = (^rdat) ^ par_odd;
    char_ticks = IW'(nbits) * IW'(OVS);
    line_ok = rxin && (!idle_mode || state == RX_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bitidx   <= '0;
      votes    <= '0;
      sh       <= '1;
      noisy    <= 1'b0;
      done     <= 1'b0;
      dout     <= '0;
      noise    <= 1'b0;
      ferr     <= 1'b0;
      perr     <= 1'b0;
      idle_hit <= 1'b0;
      icnt     <= '0;
      armed    <= 1'b0;
    end else begin
      done     <= 1'b0;
      idle_hit <= 1'b0;
      if (tick) begin
        if (line_ok) begin
          if (icnt != '1) icnt <= icnt + 1'b1;
          if (armed && (icnt + 1'b1) >= char_ticks) begin
            idle_hit <= 1'b1;
            armed    <= 1'b0;
          end
        end else begin
          icnt <= '0;
        end
        case (state)
          RX_IDLE: begin
            if (en && !rxin) begin
              state  <= RX_RUN;
              cnt    <= CW'(1);
              bitidx <= '0;
              noisy  <= 1'b0;
              armed  <= 1'b1;
            end
          end
          default: begin
            if (cnt >= CW'(V0) && cnt <= CW'(V0 + 2)) votes <= {votes[1:0], rxin};
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              if (bitidx == 4'd0 && maj) begin
                state <= RX_IDLE;
              end else begin
                sh     <= cur;
                noisy  <= noisy | dis;
                bitidx <= bitidx + 1'b1;
                if (last) begin
                  state <= RX_IDLE;
                  done  <= 1'b1;
                  dout  <= rdat;
                  noise <= noisy | dis;
                  ferr  <= !maj;
                  perr  <= par_en && (pbit != pexp);
                end
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
      if (!en) state <= RX_IDLE;
    end
  end

  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> state == RX_IDLE) else $error("receiver busy after frame"); // R2
  AST_IDLE_NEEDS_ONES: assert property (@(posedge clk) disable iff (rst)
    idle_hit |-> $past(rxin)) else $error("idle with low line"); // R7
endmodule

// File: rtl/serial_port.sv
module serial_port #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_err,
  output logic        dma_tx_req,
  output logic        dma_rx_req
);
  import sp_pkg::*;

  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  baud;
  logic [8:0]        rx_buf;
  logic              rx_full, idle_f, ovr, noise_f, ferr_f, perr_f;
  logic              rx_s1, rx_s2, rx_in;
  logic              tick;
  logic              tx_empty, tx_done, tx_load, tx_clr;
  logic              rx_done, rx_noise, rx_ferr, rx_perr, idle_hit;
  logic [8:0]        rx_dout;
  logic              msb;
  logic [7:0]        status;

  sp_baud #(.DIV_W(DIV_W)) u_baud (.clk(clk), .rst(rst), .div(baud), .tick(tick));

  assign tx_load = bus_wr && bus_addr == A_DATA && ctrl[C_TXEN];
  assign tx_clr  = bus_wr && bus_addr == A_STAT && bus_wdata[1];

  sp_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .nine(ctrl[C_NINE]), .par_en(ctrl[C_PAREN]),
    .par_odd(ctrl[C_PODD]), .load(tx_load), .ld_data(bus_wdata[8:0]), .clr_done(tx_clr),
    .txd(txd), .empty(tx_empty), .done(tx_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  assign rx_in = ctrl[C_LOOP] ? txd : rx_s2;

  sp_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxin(rx_in), .en(ctrl[C_RXEN]),
    .nine(ctrl[C_NINE]), .par_en(ctrl[C_PAREN]), .par_odd(ctrl[C_PODD]),
    .idle_mode(ctrl[C_ISTOP]), .done(rx_done), .dout(rx_dout), .noise(rx_noise),
    .ferr(rx_ferr), .perr(rx_perr), .idle_hit(idle_hit));

  assign msb    = ctrl[C_NINE] ? rx_dout[8] : rx_dout[7];
  assign status = {perr_f, ferr_f, noise_f, ovr, idle_f, rx_full, tx_done, tx_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      baud       <= '0;
      rx_buf     <= '0;
      rx_full    <= 1'b0;
      idle_f     <= 1'b0;
      ovr        <= 1'b0;
      noise_f    <= 1'b0;
      ferr_f     <= 1'b0;
      perr_f     <= 1'b0;
      bus_rdata  <= '0;
      irq_tx     <= 1'b0;
      irq_rx     <= 1'b0;
      irq_err    <= 1'b0;
      dma_tx_req <= 1'b0;
      dma_rx_req <= 1'b0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= {7'd0, rx_buf};
          A_CTRL:  bus_rdata <= 16'(ctrl);
          A_STAT:  bus_rdata <= {8'd0, status};
          default: bus_rdata <= 16'(baud);
        endcase
        if (bus_addr == A_DATA) rx_full <= 1'b0;
      end
      if (rx_done && (!ctrl[C_SBY] || (ctrl[C_WADDR] && msb))) begin
        ctrl[C_SBY] <= 1'b0;
        if (rx_full) begin
          ovr <= 1'b1;
        end else begin
          rx_buf  <= rx_dout;
          rx_full <= 1'b1;
          noise_f <= noise_f | rx_noise;
          ferr_f  <= ferr_f | rx_ferr;
          perr_f  <= perr_f | rx_perr;
        end
      end
      if (idle_hit) begin
        idle_f <= 1'b1;
        if (!ctrl[C_WADDR]) ctrl[C_SBY] <= 1'b0;
      end
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: ctrl <= bus_wdata[CTRL_W-1:0];
          A_BAUD: baud <= bus_wdata[DIV_W-1:0];
          A_STAT: begin
            if (bus_wdata[3]) idle_f  <= 1'b0;
            if (bus_wdata[4]) ovr     <= 1'b0;
            if (bus_wdata[5]) noise_f <= 1'b0;
            if (bus_wdata[6]) ferr_f  <= 1'b0;
            if (bus_wdata[7]) perr_f  <= 1'b0;
          end
          default: ;
        endcase
      end
      irq_tx     <= ctrl[C_TXIE] & ((tx_empty & !ctrl[C_TXDMA]) | tx_done);
      irq_rx     <= ctrl[C_RXIE] & ((rx_full & !ctrl[C_RXDMA]) | idle_f);
      irq_err    <= ctrl[C_ERIE] & (ovr | noise_f | ferr_f | perr_f);
      dma_tx_req <= ctrl[C_TXDMA] & ctrl[C_TXEN] & tx_empty;
      dma_rx_req <= ctrl[C_RXDMA] & rx_full;
    end
  end

  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $stable(rx_buf)) else $error("overrun overwrote buffer"); // R6
  AST_NO_FULL_IN_STANDBY: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && !$past(bus_wr)) |-> !ctrl[C_SBY]) else $error("stored while asleep"); // R8
  AST_ERR_IRQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> $past(ctrl[C_ERIE])) else $error("error irq without enable"); // R12
endmodule

// File: tb/test_serial_port.sv
`timescale 1ns/1ps
module test_serial_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq_tx, irq_rx, irq_err, dma_tx_req, dma_rx_req;

  int nchk = 0, nfail = 0, tpt = 1;

  always #2 clk = ~clk;

  serial_port i_serial_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_stat(input int b, input string tag);
    logic [15:0] s;
    bit got = 0;
    for (int i = 0; i < 6000 && !got; i++) begin
      rd(2'd2, s);
      got = s[b];
    end
    if (!got) chk(0, tag, 0, 1);
  endtask

  task automatic bits_wait(input int n);
    repeat (n * 16 * tpt) @(negedge clk);
  endtask

  function automatic logic [11:0] mkfr(input logic [8:0] d, input bit nine, input bit pe,
                                       input bit odd, input bit flip, input bit stopb);
    logic [11:0] f = '1;
    int idx = 9;
    f[0] = 1'b0;
    f[8:1] = d[7:0];
    if (nine) begin f[9] = d[8]; idx = 10; end
    if (pe) begin
      f[idx] = (^(nine ? d : {1'b0, d[7:0]})) ^ odd ^ flip;
      idx++;
    end
    f[idx] = stopb;
    return f;
  endfunction

  task automatic drive(input logic [11:0] f, input int nb, input int gbit);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rxd = f[i];
      if (i == gbit) begin
        repeat (8 * tpt - 1) @(negedge clk);
        rxd = ~f[i];
        repeat (tpt) @(negedge clk);
        rxd = f[i];
        repeat (7 * tpt) @(negedge clk);
      end else begin
        repeat (16 * tpt - 1) @(negedge clk);
      end
    end
    @(negedge clk); rxd = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] d, s;
    logic [9:0] cap;
    logic [8:0] v;
    bit seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    rd(2'd2, s);
    chk(s == 16'h0001, "R1 status after reset", s, 1);
    rd(2'd3, d);
    chk(d == 16'h0000, "R1 divider after reset", d, 0);
    chk({txd, irq_tx, irq_rx, irq_err, dma_tx_req, dma_rx_req} == 6'b100000,
        "R1 pins after reset", {txd, irq_tx, irq_rx, irq_err, dma_tx_req, dma_rx_req}, 6'b100000);

    // R2 frame on the txd pin
    tpt = 2;
    wr(2'd3, 16'd2);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h006B);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      seen = !txd;
    end
    repeat (8 * tpt) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      cap[i] = txd;
      if (i < 9) repeat (16 * tpt) @(negedge clk);
    end
    chk(cap == {1'b1, 8'h6B, 1'b0}, "R2 txd frame bits", cap, {1'b1, 8'h6B, 1'b0});
    wait_stat(1, "R11 transmit complete timeout");
    rd(2'd2, s);
    chk(s[1:0] == 2'b11, "R11 empty and complete", s[1:0], 3);
    wr(2'd2, 16'h0002);
    rd(2'd2, s);
    chk(s[1] == 1'b0, "R13 complete cleared by W1C", s[1], 0);

    // R11 holding register busy
    wr(2'd0, 16'h0011);
    wr(2'd0, 16'h0022);
    rd(2'd2, s);
    chk(s[1:0] == 2'b00, "R11 holding full while shifting", s[1:0], 0);
    wait_stat(1, "R11 second complete timeout");

    // R12 transmit interrupt and DMA
    wr(2'd2, 16'h0002);
    wr(2'd1, 16'h0201);
    repeat (3) @(negedge clk);
    chk(irq_tx == 1'b1, "R12 irq_tx on empty", irq_tx, 1);
    wr(2'd1, 16'h1201);
    repeat (3) @(negedge clk);
    chk({dma_tx_req, irq_tx} == 2'b10, "R12 tx steered to DMA", {dma_tx_req, irq_tx}, 2);

    // R2 R3 R10 loop sweep, 8-bit even parity, pin held low
    rxd = 1'b0;
    tpt = 1;
    wr(2'd3, 16'd1);
    wr(2'd1, 16'h010B);
    for (int k = 0; k < 256; k++) begin
      wr(2'd0, 16'(k));
      wait_stat(2, "R10 loop receive timeout");
      rd(2'd0, d);
      chk(d == 16'(k), "R2 R10 loop 8-bit data", d, k);
      rd(2'd2, s);
      chk((s & 16'h00F4) == 0, "R3 R13 no errors and full cleared", s, 0);
    end

    // R2 R3 nine-bit odd parity
    wr(2'd1, 16'h011F);
    for (int k = 0; k < 16; k++) begin
      v = 9'((k * 37 + 5) ^ ((k & 1) << 8));
      wr(2'd0, 16'(v));
      wait_stat(2, "R2 nine-bit receive timeout");
      rd(2'd0, d);
      chk(d == 16'(v), "R2 R3 loop 9-bit odd data", d, v);
      rd(2'd2, s);
      chk(s[7] == 1'b0, "R3 odd parity accepted", s[7], 0);
    end

    // R6 overrun
    wr(2'd1, 16'h010B);
    wr(2'd2, 16'h00FA);
    wr(2'd0, 16'h0011);
    wr(2'd0, 16'h0022);
    wait_stat(4, "R6 overrun timeout");
    rd(2'd0, d);
    chk(d == 16'h0011, "R6 buffer keeps first", d, 16'h11);

    // R12 receive DMA
    wr(2'd2, 16'h00FA);
    wr(2'd1, 16'h250B);
    wr(2'd0, 16'h003C);
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      seen = dma_rx_req;
    end
    chk({seen, irq_rx} == 2'b10, "R12 rx steered to DMA", {seen, irq_rx}, 2);
    rd(2'd0, d);
    repeat (2) @(negedge clk);
    chk(dma_rx_req == 1'b0, "R12 dma_rx_req drops after read", dma_rx_req, 0);

    // pin-driven tests
    rxd = 1'b1;
    tpt = 4;
    wr(2'd3, 16'd4);
    wr(2'd1, 16'h080A);
    bits_wait(12);
    wr(2'd2, 16'h00FA);
    rd(2'd0, d);
    drive(mkfr(9'h05A, 0, 1, 0, 1, 1), 11, -1);
    wait_stat(2, "R3 parity frame timeout");
    rd(2'd0, d);
    chk(d == 16'h005A, "R3 data with bad parity", d, 16'h5A);
    rd(2'd2, s);
    chk(s[7:6] == 2'b10, "R3 parity error flag", s[7:6], 2);
    repeat (2) @(negedge clk);
    chk(irq_err == 1'b1, "R12 irq_err on parity error", irq_err, 1);

    wr(2'd1, 16'h0002);
    wr(2'd2, 16'h00FA);
    drive(mkfr(9'h033, 0, 0, 0, 0, 0), 10, -1);
    wait_stat(2, "R5 framing frame timeout");
    rd(2'd0, d);
    chk(d == 16'h0033, "R5 data kept on framing error", d, 16'h33);
    rd(2'd2, s);
    chk(s[6] == 1'b1, "R5 framing flag", s[6], 1);

    wr(2'd2, 16'h00FA);
    drive(mkfr(9'h0A5, 0, 0, 0, 0, 1), 10, 3);
    wait_stat(2, "R4 noise frame timeout");
    rd(2'd0, d);
    chk(d == 16'h00A5, "R4 voted data despite glitch", d, 16'hA5);
    rd(2'd2, s);
    chk(s[6:5] == 2'b01, "R4 noise flag", s[6:5], 1);

    // R7 idle counting methods
    wr(2'd2, 16'h00FA);
    drive(mkfr(9'h0F0, 0, 0, 0, 0, 1), 10, -1);
    bits_wait(7);
    rd(2'd2, s);
    chk(s[3] == 1'b1, "R7 idle from start bit", s[3], 1);
    rd(2'd0, d);
    wr(2'd1, 16'h0022);
    bits_wait(12);
    wr(2'd2, 16'h00FA);
    drive(mkfr(9'h0F0, 0, 0, 0, 0, 1), 10, -1);
    bits_wait(7);
    rd(2'd2, s);
    chk(s[3] == 1'b0, "R7 no idle yet after stop", s[3], 0);
    bits_wait(4);
    rd(2'd2, s);
    chk(s[3] == 1'b1, "R7 idle after stop method", s[3], 1);
    rd(2'd0, d);

    // R8 address wakeup
    wr(2'd1, 16'h00C2);
    wr(2'd2, 16'h00FA);
    drive(mkfr(9'h012, 0, 0, 0, 0, 1), 10, -1);
    bits_wait(1);
    rd(2'd2, s);
    chk(s[2] == 1'b0, "R8 low top bit ignored", s[2], 0);
    drive(mkfr(9'h085, 0, 0, 0, 0, 1), 10, -1);
    wait_stat(2, "R8 address wake timeout");
    rd(2'd0, d);
    chk(d == 16'h0085, "R8 address char received", d, 16'h85);
    rd(2'd1, d);
    chk(d[7] == 1'b0, "R8 standby cleared", d[7], 0);

    // R9 idle wakeup
    bits_wait(12);
    wr(2'd1, 16'h0082);
    drive(mkfr(9'h034, 0, 0, 0, 0, 1), 10, -1);
    bits_wait(1);
    rd(2'd2, s);
    chk(s[2] == 1'b0, "R9 char ignored in standby", s[2], 0);
    rd(2'd1, d);
    chk(d[7] == 1'b1, "R9 still in standby", d[7], 1);
    bits_wait(12);
    rd(2'd1, d);
    chk(d[7] == 1'b0, "R9 woken by idle", d[7], 0);
    drive(mkfr(9'h056, 0, 0, 0, 0, 1), 10, -1);
    wait_stat(2, "R9 post-wake timeout");
    rd(2'd0, d);
    chk(d == 16'h0056, "R9 char after wake", d, 16'h56);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule